// File: doc/BRIEF.md
# AAL1 Transmit Timestamp Header Inserter

This block sits in the transmit path of an AAL1 segmentation engine. For each outgoing cell it receives the one-byte SAR header and returns the final header one clock later. The header holds a convergence-sublayer indication (CSI) bit, a 3-bit sequence number (SN) and a 4-bit protection field.

When timestamp mode is on for the channel, the CSI bit of the odd-numbered cells carries a 4-bit residual time code, one bit per cell. The code is read once per eight-cell sequence cycle. At the SN=0 cell the block raises a byte-read request with a 4-bit address, and a valid strobe returns the byte. The protection field is always rebuilt after the CSI bit is settled.

If the read is late, the previous code is sent again and a sticky underrun flag is raised. The cell payload, the bus that serves the read and the receive side lie outside this block.

Top module: `srts_hdr_insert`

## Requirements
- R1: Each header presented with `hdr_valid_i` high appears on `hdr_o` with `hdr_valid_o` high exactly one clock later. `hdr_valid_o` is low in every other cycle.
- R2: Output header layout: bit 7 is CSI and bits 6:4 are SN, copied unchanged from the input. Bits 3:1 are the remainder of {CSI,SN}·x^3 divided by x^3+x+1, with CSI as the most significant data bit. Bit 0 makes the count of ones in bits 7:0 even.
- R3: With `srts_en_i` low, CSI is copied from the input and no read request is raised.
- R4: With `srts_en_i` high, cells with an even SN keep their input CSI.
- R5: With `srts_en_i` high, the CSI of cells with an odd SN is taken from the current code: SN=1 takes bit 3, SN=3 takes bit 2, SN=5 takes bit 1 and SN=7 takes bit 0.
- R6: An enabled SN=0 cell raises `fetch_req_o` in the next cycle. `fetch_addr_o` equals the `addr_sel_i` value sampled with that cell. The request stays high until a cycle with `fetch_valid_i` high, or until an enabled SN=1 cell, whichever comes first.
- R7: Only bits 3:0 of `fetch_data_i` form the code (bit 0 least significant). Bits 7:4 are ignored, and so is `fetch_valid_i` while no request is pending.
- R8: A returned code takes effect at the next enabled SN=1 cell and stays in use for SN=3, 5 and 7, whatever arrives in between.
- R9: If no data has returned before the enabled SN=1 cell arrives, the previous code is reused and `underrun_o` goes high and stays high. Data returned in that same cycle is discarded.
- R10: After reset all outputs are low and the stored code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hdr_valid_i | input | 1 | Input header strobe |
| hdr_i | input | 8 | Input SAR header |
| srts_en_i | input | 1 | Timestamp insertion enable for the channel |
| addr_sel_i | input | 4 | Code read address for the channel |
| fetch_req_o | output | 1 | Code read request |
| fetch_addr_o | output | 4 | Code read address |
| fetch_valid_i | input | 1 | Read data strobe |
| fetch_data_i | input | 8 | Read data byte |
| hdr_valid_o | output | 1 | Output header strobe |
| hdr_o | output | 8 | Final SAR header |
| underrun_o | output | 1 | Sticky late-code flag |

## Verification
Every result is due one clock edge after the stimulus that causes it: the output header, the rise or fall of the request, and the setting of the underrun flag. The bench drives inputs on the falling edge. At the next falling edge it compares all outputs against a model state it advanced from the same inputs, so each sample falls half a period after the single register stage. The response delay of the read is randomised, including responses in the same cycle as the SN=1 cell and after it, so that both late-code paths are exercised.

// File: rtl/srts_pkg.sv
package srts_pkg;
  localparam int SN_W   = 3;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 3;
  localparam int DATA_W = 1 + SN_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 3'b011;

  typedef struct packed {
    logic            csi;
    logic [SN_W-1:0] sn;
    logic [CRC_W-1:0] crc;
    logic            par;
  } sar_hdr_t;

  function automatic logic [CRC_W-1:0] crc3(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W-1; i >= 0; i--) begin
      fb = d[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/srts_code_fetch.sv
module srts_code_fetch
  import srts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_v_i,
  input  logic [SN_W-1:0]   sn_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_sel_i,
  input  logic              fetch_valid_i,
  input  logic [BYTE_W-1:0] fetch_data_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              underrun_o
);
  logic [CODE_W-1:0] new_q, act_q;
  logic got_q, req_q, und_q;
  logic [ADDR_W-1:0] addr_q;
  logic at_start, at_load;

  assign at_start = cell_v_i && en_i && (sn_i == SN_W'(0));
  assign at_load  = cell_v_i && en_i && (sn_i == SN_W'(1));
  // fresh code applies from SN=1 onward
  assign code_o = (at_load && got_q) ? new_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_q  <= '0;
      act_q  <= '0;
      got_q  <= 1'b0;
      req_q  <= 1'b0;
      und_q  <= 1'b0;
      addr_q <= '0;
    end else if (at_load) begin
      act_q <= code_o;
      if (!got_q) und_q <= 1'b1;
      got_q <= 1'b0;
      req_q <= 1'b0;
    end else if (at_start) begin
      req_q  <= 1'b1;
      addr_q <= addr_sel_i;
      got_q  <= 1'b0;
    end else if (req_q && fetch_valid_i) begin
      new_q <= fetch_data_i[CODE_W-1:0];
      got_q <= 1'b1;
      req_q <= 1'b0;
    end
  end

  assign fetch_req_o  = req_q;
  assign fetch_addr_o = addr_q;
  assign underrun_o   = und_q;

  a_r9_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  a_r6_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && $past(fetch_req_o) |-> $stable(fetch_addr_o));
  a_r6_req_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req_o) |-> $past(at_start));
endmodule

// File: rtl/srts_csi_mux.sv
module srts_csi_mux
  import srts_pkg::*;
(
  input  logic              csi_i,
  input  logic [SN_W-1:0]   sn_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              csi_o
);
  logic [CODE_W-1:0] sel_oh;

  // odd SN 1,3,5,7 -> code bit 3,2,1,0
  for (genvar g = 0; g < CODE_W; g++) begin : g_sel
    assign sel_oh[g] = (sn_i[SN_W-1:1] == (SN_W-1)'(CODE_W-1-g));
  end

  always_comb begin
    csi_o = csi_i;
    if (en_i && sn_i[0]) csi_o = |(sel_oh & code_i);
  end
endmodule

// File: rtl/sar_hdr_protect.sv
module sar_hdr_protect
  import srts_pkg::*;
(
  input  logic            csi_i,
  input  logic [SN_W-1:0] sn_i,
  output sar_hdr_t        hdr_o
);
  always_comb begin
    hdr_o.csi = csi_i;
    hdr_o.sn  = sn_i;
    hdr_o.crc = crc3({csi_i, sn_i});
    hdr_o.par = ^{csi_i, sn_i, hdr_o.crc};
  end
endmodule

// File: rtl/srts_hdr_insert.sv
module srts_hdr_insert
  import srts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [7:0]        hdr_i,
  input  logic              srts_en_i,
  input  logic [3:0]        addr_sel_i,
  output logic              fetch_req_o,
  output logic [3:0]        fetch_addr_o,
  input  logic              fetch_valid_i,
  input  logic [7:0]        fetch_data_i,
  output logic              hdr_valid_o,
  output logic [7:0]        hdr_o,
  output logic              underrun_o
);
  sar_hdr_t in_hdr, new_hdr;
  logic [CODE_W-1:0] code;
  logic csi;
  logic vld_q;
  sar_hdr_t hdr_q;

  assign in_hdr = sar_hdr_t'(hdr_i);

  srts_code_fetch u_fetch (
    .clk_i, .rst_ni,
    .cell_v_i(hdr_valid_i), .sn_i(in_hdr.sn), .en_i(srts_en_i),
    .addr_sel_i, .fetch_valid_i, .fetch_data_i,
    .fetch_req_o, .fetch_addr_o, .code_o(code), .underrun_o
  );

  srts_csi_mux u_mux (
    .csi_i(in_hdr.csi), .sn_i(in_hdr.sn), .en_i(srts_en_i),
    .code_i(code), .csi_o(csi)
  );

  sar_hdr_protect u_prot (.csi_i(csi), .sn_i(in_hdr.sn), .hdr_o(new_hdr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      vld_q <= hdr_valid_i;
      if (hdr_valid_i) hdr_q <= new_hdr;
    end
  end

  assign hdr_valid_o = vld_q;
  assign hdr_o       = hdr_q;

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> hdr_valid_o);
  a_r4_even_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && srts_en_i && !hdr_i[4] |=> hdr_o[7] == $past(hdr_i[7]));
  a_r3_off_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && !srts_en_i |=> hdr_o[7] == $past(hdr_i[7]));
  a_r2_even_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> !(^hdr_o));
  a_r2_sn_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> hdr_o[6:4] == $past(hdr_i[6:4]));
endmodule

// File: tb/tb_srts_hdr_insert.sv
module tb_srts_hdr_insert;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hv = 1'b0, en = 1'b0, fv = 1'b0;
  logic [7:0] hi = '0, fd = '0;
  logic [3:0] sel = '0;
  logic req, hvo, und;
  logic [3:0] addr;
  logic [7:0] ho;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srts_hdr_insert dut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hv), .hdr_i(hi),
    .srts_en_i(en), .addr_sel_i(sel), .fetch_req_o(req), .fetch_addr_o(addr),
    .fetch_valid_i(fv), .fetch_data_i(fd), .hdr_valid_o(hvo), .hdr_o(ho),
    .underrun_o(und)
  );

  // model state
  bit m_req, m_got, m_und;
  logic [3:0] m_addr, m_new, m_act;
  bit e_v; logic [7:0] e_h; string e_tag;
  int sn = 0, resp_cnt = 0;

  function automatic logic [2:0] ref_crc(input logic [3:0] d);
    logic [6:0] v;
    v = {d, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b1011 << (i - 3));
    return v[2:0];
  endfunction

  function automatic logic [7:0] ref_hdr(input logic c, input logic [2:0] s);
    logic [2:0] r;
    r = ref_crc({c, s});
    return {c, s, r, ^{c, s, r}};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R1 valid", int'(hvo), int'(e_v));
    if (e_v) begin
      chk({e_tag, " csi"}, int'(ho[7]), int'(e_h[7]));
      chk("R2 sn/crc/parity", int'(ho[6:0]), int'(e_h[6:0]));
    end
    chk("R6 req", int'(req), int'(m_req));
    if (m_req) chk("R6 addr", int'(addr), int'(m_addr));
    chk("R9 underrun", int'(und), int'(m_und));
  endtask

  // mode: 0 prompt, 1 never, 2 random; pct = cell probability
  task automatic step(input int mode, input int pct, input bit ena);
    logic c, csi; logic [3:0] code;
    bit lo, st;
    hv = ($urandom_range(99) < pct);
    en = ena;
    sel = 4'($urandom);
    c = 1'($urandom);
    hi = {c, 3'(sn), 4'($urandom)};
    fv = 1'b0; fd = 8'($urandom);
    if (m_req) begin
      if (mode == 0) fv = 1'b1;
      else if (mode == 2) begin
        if (resp_cnt == 0) fv = 1'b1; else resp_cnt--;
      end
    end else if (mode == 2) fv = ($urandom_range(3) == 0);
    lo = hv && en && (sn == 1);
    st = hv && en && (sn == 0);
    code = (lo && m_got) ? m_new : m_act;
    csi = c;
    e_tag = en ? "R4" : "R3";
    if (en && sn[0]) begin
      csi = code[3 - (sn >> 1)];
      e_tag = "R5 R7 R8 R9";
    end
    e_v = hv;
    e_h = ref_hdr(csi, 3'(sn));
    if (lo) begin
      m_act = code;
      if (!m_got) m_und = 1;
      m_got = 0; m_req = 0;
    end else if (st) begin
      m_req = 1; m_addr = sel; m_got = 0;
      resp_cnt = $urandom_range(8);
    end else if (m_req && fv) begin
      m_new = fd[3:0]; m_got = 1; m_req = 0;
    end
    if (hv) sn = (sn + 1) % 8;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic run_cells(input int n, input int mode, input int pct, input bit ena);
    int start;
    start = 0;
    while (start < n) begin
      step(mode, pct, ena);
      if (e_v) start++;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_req = 0; m_got = 0; m_und = 0; m_addr = '0; m_new = '0; m_act = '0;
    e_v = 0; e_h = '0; e_tag = "R1";
    @(negedge clk);
    chk("R10 valid", int'(hvo), 0);
    chk("R10 hdr", int'(ho), 0);
    chk("R10 req", int'(req), 0);
    chk("R10 underrun", int'(und), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: fixed code 0xA5 (low nibble 5 -> SN1..7 csi 0,1,0,1)
    en = 1; hv = 1; hi = {1'b1, 3'd0, 4'h0}; fv = 0;
    @(negedge clk);
    hv = 0; fv = 1; fd = 8'hA5;
    @(negedge clk);
    fv = 0;
    for (int k = 1; k < 8; k++) begin
      hv = 1; hi = {1'b1, 3'(k), 4'h0};
      @(negedge clk);
      hv = 0;
      if (k[0]) chk("R5 R7 directed csi", int'(ho[7]), (k == 3 || k == 7) ? 1 : 0);
      else chk("R4 directed csi", int'(ho[7]), 1);
      chk("R2 directed crc", int'(ho[6:0]), int'(ref_hdr(ho[7], 3'(k)) & 8'h7F));
    end
    chk("R9 no underrun", int'(und), 0);
    m_act = 4'h5;
    sn = 0;
    run_cells(16, 2, 50, 1'b0);
    run_cells(24, 0, 40, 1'b1);
    run_cells(16, 1, 60, 1'b1);
    for (int g = 0; g < 50; g++) run_cells(8, 2, 30 + 10 * (g % 7), 1'(g % 3 != 0));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule